// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when a synchronous DRAM needs a refresh. An 8-bit up-counter advances on a prescaled tick, and a 3-bit clock-select field picks the prescale ratio. On each tick the counter is compared with a programmable limit register. When the two are equal, the counter restarts from zero and a refresh request is raised. The request stays up until the memory sequencer acknowledges it. If a further match arrives while a request is still outstanding, a sticky overflow flag records the miss.

Two control bits choose the operating mode. With refresh enabled and the mode bit clear, the block runs periodic auto-refresh. With both bits set, it holds the memory in low-power self-refresh and raises no periodic requests. When a single control write leaves self-refresh for auto-refresh, the block releases the hold and issues one refresh request straight away. Software writes the limit, the counter and the mode bits first and the clock select last. Counting then starts from whatever value the counter holds.

Top module: `sdram_refresh_timer`

## Requirements
- R1: After reset the counter reads 0, the counter is stopped (clock select 0), refresh is disabled, and `refresh_req`, `self_refresh_hold` and `overflow` are all 0.
- R2: When the clock-select field (control bits [2:0]) is 000, the counter holds its value.
- R3: Clock-select codes 1 to 7 divide the input clock by 4, 16, 64, 256, 1024, 2048 and 4096. Every control write (address 0) restarts the prescale phase, so the counter first advances one full divide period after that write.
- R4: A write to address 1 loads the counter, and `count_value` shows the new value in the next cycle. Counting continues from the loaded value.
- R5: On each tick, a counter equal to the limit register (address 2) is cleared to 0. Any other value is incremented, and 255 wraps to 0.
- R6: In auto mode (control bit 3 = 1, bit 4 = 0), a match raises `refresh_req` in the next cycle. It stays high until `ack` is seen high.
- R7: With refresh disabled (bit 3 = 0), matches raise no request, but the counter still runs.
- R8: With bits 3 and 4 both set, `self_refresh_hold` is 1 and no new request is raised.
- R9: A control write that clears bit 4 while keeping bit 3 set, made while in self-refresh, drops `self_refresh_hold` and raises `refresh_req` in the next cycle.
- R10: A new request while `refresh_req` is high and `ack` is low sets `overflow`. `overflow` stays set until a control write with bit 7 set. A set event in the same cycle takes priority over the clear.
- R11: When `ack` and a new request arrive in the same cycle, `refresh_req` stays high and `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 counter, 2 limit, 3 unused |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Sequencer has taken the pending request |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| self_refresh_hold | output | 1 | Keep memory in self-refresh |
| overflow | output | 1 | Sticky flag for a request lost while one was pending |
| count_value | output | 8 | Current counter value |

## Verification
The main counting path is tried with several divide codes (fast, middle and slowest). This separates a wrong ratio from a wrong phase restart. It is also tried with a limit of zero, a small limit and a limit above the start value, so the match-and-clear case is told apart from a plain 8-bit wrap. Acknowledge is held off, pulsed, and held high across a coincident match, which separates correct pending behaviour, overflow setting and the ack-versus-new-request case. The mode codes are covered with disabled, auto, self-refresh and the self-to-auto exit, which shows whether suppression and the immediate exit request are decoded correctly.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_LIMIT = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_SELF = 2'd2
  } refresh_mode_e;

  localparam int unsigned SEL_W       = 3;
  localparam int unsigned EN_BIT      = 3;
  localparam int unsigned MODE_BIT    = 4;
  localparam int unsigned OVF_CLR_BIT = 7;

  // Divide ratio selected by the clock-select code; 0 means stopped.
  function automatic int unsigned div_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 4;
      3'd2:    return 16;
      3'd3:    return 64;
      3'd4:    return 256;
      3'd5:    return 1024;
      3'd6:    return 2048;
      3'd7:    return 4096;
      default: return 0;
    endcase
  endfunction

  function automatic refresh_mode_e decode_mode(input logic enable, input logic self_sel);
    if (!enable)      return MODE_OFF;
    else if (self_sel) return MODE_SELF;
    else               return MODE_AUTO;
  endfunction

endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import refresh_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] terminal;

  always_comb begin
    terminal = PRE_W'(div_ratio(clk_sel) - 1);
    tick     = (clk_sel != '0) && (phase_q == terminal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (restart)         phase_q <= '0;
    else if (clk_sel == '0)   phase_q <= '0;
    else if (tick)            phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             match
);
  assign match = tick && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= load_val;
    else if (match) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end
endmodule

// File: rtl/rt_request.sv
module rt_request (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic auto_en,
  input  logic exit_evt,
  input  logic ack,
  input  logic ovf_clr,
  output logic new_req,
  output logic pending,
  output logic overflow
);
  assign new_req = (match && auto_en) || exit_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      pending  <= (pending && !ack) || new_req;
      overflow <= (overflow && !ovf_clr) || (new_req && pending && !ack);
    end
  end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
  import refresh_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ack,
  output logic             refresh_req,
  output logic             self_refresh_hold,
  output logic             overflow,
  output logic [CNT_W-1:0] count_value
);
  logic [SEL_W-1:0] clk_sel;
  logic             en_q;
  logic             self_q;
  logic [CNT_W-1:0] limit_q;
  logic             ctrl_wr;
  logic             cnt_wr;
  logic             limit_wr;
  logic             ovf_clr;
  logic             exit_evt;
  logic             auto_en;
  logic             tick;
  logic             match_evt;
  logic             new_req;
  refresh_mode_e    mode_now;

  assign ctrl_wr  = wr_en && (wr_addr == REG_CTRL);
  assign cnt_wr   = wr_en && (wr_addr == REG_COUNT);
  assign limit_wr = wr_en && (wr_addr == REG_LIMIT);
  assign ovf_clr  = ctrl_wr && wr_data[OVF_CLR_BIT];

  assign mode_now = decode_mode(en_q, self_q);
  assign auto_en  = (mode_now == MODE_AUTO);
  assign self_refresh_hold = (mode_now == MODE_SELF);
  assign exit_evt = ctrl_wr && (mode_now == MODE_SELF) &&
                    (decode_mode(wr_data[EN_BIT], wr_data[MODE_BIT]) == MODE_AUTO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel <= '0;
      en_q    <= 1'b0;
      self_q  <= 1'b0;
      limit_q <= '0;
    end else begin
      if (ctrl_wr) begin
        clk_sel <= wr_data[SEL_W-1:0];
        en_q    <= wr_data[EN_BIT];
        self_q  <= wr_data[MODE_BIT];
      end
      if (limit_wr) limit_q <= wr_data;
    end
  end

  rt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .clk_sel(clk_sel), .tick(tick)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr), .load_val(wr_data),
    .limit(limit_q), .count(count_value), .match(match_evt)
  );

  rt_request u_req (
    .clk(clk), .rst_n(rst_n), .match(match_evt), .auto_en(auto_en),
    .exit_evt(exit_evt), .ack(ack), .ovf_clr(ovf_clr), .new_req(new_req),
    .pending(refresh_req), .overflow(overflow)
  );
endmodule

// File: rtl/refresh_timer_checker.sv
module refresh_timer_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             ack,
  input logic             refresh_req,
  input logic             self_refresh_hold,
  input logic             overflow,
  input logic [CNT_W-1:0] count_value,
  input logic [2:0]       clk_sel,
  input logic             match_evt,
  input logic             new_req
);
  logic cnt_wr, clr_wr, exit_wr;
  assign cnt_wr  = wr_en && (wr_addr == 2'd1);
  assign clr_wr  = wr_en && (wr_addr == 2'd0) && wr_data[7];
  assign exit_wr = wr_en && (wr_addr == 2'd0) && self_refresh_hold && wr_data[3] && !wr_data[4];

  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(count_value));

  a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cnt_wr) |=> (count_value == '0));

  a_r6_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !ack) |=> refresh_req);

  a_r8_no_new_in_self: assert property (@(posedge clk) disable iff (!rst_n)
    (self_refresh_hold && $past(self_refresh_hold)) |-> !$rose(refresh_req));

  a_r9_exit_request: assert property (@(posedge clk) disable iff (!rst_n)
    exit_wr |=> (refresh_req && !self_refresh_hold));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_wr) |=> overflow);

  a_r11_ack_with_new: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && ack && new_req) |=> refresh_req);
endmodule

bind sdram_refresh_timer refresh_timer_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ack(ack), .refresh_req(refresh_req), .self_refresh_hold(self_refresh_hold),
  .overflow(overflow), .count_value(count_value), .clk_sel(clk_sel),
  .match_evt(match_evt), .new_req(new_req)
);

// File: tb/test_sdram_refresh_timer.sv
`timescale 1ns/1ps
module test_sdram_refresh_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ack = 1'b0;
  logic       refresh_req, self_refresh_hold, overflow;
  logic [7:0] count_value;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  sdram_refresh_timer i_sdram_refresh_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack(ack), .refresh_req(refresh_req), .self_refresh_hold(self_refresh_hold),
    .overflow(overflow), .count_value(count_value)
  );

  // Behavioural reference model
  int m_phase, m_cnt, m_limit, m_sel;
  bit m_en, m_self, m_pend, m_ovf;

  function automatic int period_of(int s);
    if (s == 0) return 0;
    if (s <= 4) return 1 << (2 * s);
    return 1024 << (s - 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_limit = 0; m_sel = 0;
      m_en = 0; m_self = 0; m_pend = 0; m_ovf = 0;
    end else begin
      bit t, hit, nr, exit_w, ctrl_w;
      ctrl_w = wr_en && wr_addr == 2'd0;
      t      = (m_sel != 0) && (m_phase == period_of(m_sel) - 1);
      hit    = t && (m_cnt == m_limit);
      exit_w = ctrl_w && m_en && m_self && wr_data[3] && !wr_data[4];
      nr     = (hit && m_en && !m_self) || exit_w;
      m_ovf  = (m_ovf && !(ctrl_w && wr_data[7])) || (nr && m_pend && !ack);
      m_pend = (m_pend && !ack) || nr;
      if (wr_en && wr_addr == 2'd1) m_cnt = wr_data;
      else if (hit) m_cnt = 0;
      else if (t) m_cnt = (m_cnt + 1) % 256;
      if (ctrl_w || m_sel == 0 || t) m_phase = 0; else m_phase++;
      if (ctrl_w) begin m_sel = wr_data[2:0]; m_en = wr_data[3]; m_self = wr_data[4]; end
      if (wr_en && wr_addr == 2'd2) m_limit = wr_data;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, refresh_req, m_pend, "model refresh_req");
      check(phase, self_refresh_hold, m_en && m_self, "model hold");
      check(phase, overflow, m_ovf, "model overflow");
      check(phase, count_value, m_cnt, "model count");
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      summary();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic quiesce();
    wr(2'd0, 8'h80);
    pulse_ack();
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", count_value, 0, "count");
    check("R1", refresh_req, 0, "req");
    check("R1", self_refresh_hold, 0, "hold");
    check("R1", overflow, 0, "overflow");

    // R2 stopped counter, R4 counter load
    phase = "R2";
    wr(2'd2, 8'd3);
    wait_n(20);
    check("R2", count_value, 0, "count stopped");
    phase = "R4";
    wr(2'd1, 8'd5);
    check("R4", count_value, 5, "count loaded");
    wait_n(20);
    check("R2", count_value, 5, "loaded value held while stopped");

    // R6 auto-refresh period, R5 match, R3 ratio 4
    phase = "R6";
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h09);
    begin
      int n = 0;
      while (!refresh_req && n < 100) begin @(negedge clk); n++; end
      check("R6", n, 16, "cycles to first request");
      check("R5", count_value, 0, "count cleared by match");
    end
    wait_n(15);
    check("R6", refresh_req, 1, "request held without ack");
    check("R10", overflow, 0, "no overflow before second match");
    phase = "R10";
    wait_n(1);
    check("R10", overflow, 1, "overflow on second match");
    wr(2'd0, 8'h89);
    check("R10", overflow, 0, "overflow cleared by bit 7");
    pulse_ack();
    check("R6", refresh_req, 0, "request dropped by ack");

    // R11 ack coinciding with a new request
    phase = "R11";
    quiesce();
    wr(2'd2, 8'd0);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h09);
    ack = 1'b1;
    wait_n(4);
    check("R11", refresh_req, 1, "first request");
    wait_n(1);
    check("R11", refresh_req, 0, "acked");
    wait_n(3);
    check("R11", refresh_req, 1, "new request with ack");
    check("R11", overflow, 0, "no overflow with ack");
    ack = 1'b0;

    // R7 disabled, R5 wrap
    phase = "R7";
    quiesce();
    wr(2'd2, 8'd100);
    wr(2'd1, 8'd254);
    wr(2'd0, 8'h01);
    wait_n(8);
    check("R5", count_value, 0, "wrap from 255");
    check("R7", refresh_req, 0, "no request when disabled");
    wait_n(40);
    check("R7", count_value, 10, "counter runs while disabled");
    check("R7", refresh_req, 0, "still no request");

    // R3 divide ratios 16, 1024, 4096
    phase = "R3";
    quiesce();
    wr(2'd2, 8'd255);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h02);
    wait_n(47);
    check("R3", count_value, 2, "div16 before third tick");
    wait_n(1);
    check("R3", count_value, 3, "div16 third tick");
    quiesce();
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h05);
    wait_n(1023);
    check("R3", count_value, 0, "div1024 before tick");
    wait_n(1);
    check("R3", count_value, 1, "div1024 tick");
    quiesce();
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h07);
    wait_n(4095);
    check("R3", count_value, 0, "div4096 before tick");
    wait_n(1);
    check("R3", count_value, 1, "div4096 tick");

    // R8 self-refresh, R9 exit
    phase = "R8";
    quiesce();
    wr(2'd2, 8'd0);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h19);
    check("R8", self_refresh_hold, 1, "hold asserted");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R8", refresh_req, 0, "no request in self-refresh");
    end
    phase = "R9";
    wr(2'd0, 8'h09);
    check("R9", refresh_req, 1, "immediate request on exit");
    check("R9", self_refresh_hold, 0, "hold released");
    wait_n(2);
    summary();
  end
endmodule